// File: doc/BRIEF.md
# Two-Phase Bundled-Data Pipeline

This block is a linear chain of pipeline stages that pass data items between neighbours using two-phase transition signalling. A single toggle of a request wire announces a new item, and a single toggle of the matching acknowledge wire confirms it was taken. A rising toggle and a falling toggle carry the same meaning. Each stage is controlled by a Muller C-element. One input of that element is the incoming request. The other is the inverted acknowledge returned by the right neighbour.

When the C-element output toggles, three things happen. The toggle is the acknowledge to the left neighbour. It loads the incoming data into the stage register, which therefore captures on both edges of the control signal. It also starts the outgoing request, which toggles only after a bundling delay, so the data is settled before the next stage reacts. The whole chain is sampled by one fast oversampling clock. The bundling delay is a parameter counted in cycles of that clock. The left edge of the chain connects to a producer and the right edge to a consumer.

Top module: `mp_chain`

## Requirements
- R1: While `rst_ni` is low, and directly after it rises, `ack_o` is 0, `req_o` is 0 and `data_o` is 0.
- R2: `ack_o` toggles only while a request is pending at the left edge, meaning `req_i` differs from `ack_o`.
- R3: When the first stage is empty, `ack_o` takes the value of `req_i` one clock after the edge at which the toggled `req_i` is first sampled.
- R4: A stage register captures its input data on a rising toggle of its control signal and also on a falling toggle.
- R5: In an empty chain, `req_o` toggles STAGES*(DELAY+1) clocks after the edge that samples a toggle of `req_i`. At that point `data_o` holds the item that was sent.
- R6: While `req_o` differs from `ack_i`, `data_o` does not change.
- R7: `req_o` toggles only when the previous outgoing request has been acknowledged, meaning `req_o` equals `ack_i` beforehand.
- R8: Items leave at `data_o` in the order they entered at `data_i`. No item is lost and none is duplicated, under any delay on `req_i` and `ack_i`.
- R9: If `ack_i` is held, the chain accepts exactly STAGES items. A further request is not acknowledged, and `data_o` keeps showing the oldest item.
- R10: A stream of 20 items alternating between all-ones and all-zeros crosses the chain one item per request toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request toggle from the producer |
| ack_o | output | 1 | Acknowledge toggle to the producer |
| data_i | input | DATA_W | Data bundled with `req_i` |
| req_o | output | 1 | Request toggle to the consumer |
| ack_i | input | 1 | Acknowledge toggle from the consumer |
| data_o | output | DATA_W | Data bundled with `req_o` |

## Verification
The acknowledge to the left is due one clock after a toggle of `req_i` is sampled. An item reaches the right edge of an empty chain after STAGES*(DELAY+1) clocks. The bench drives inputs on falling edges and samples 2 time units after the falling edge. Its latency checks expect `req_o` unchanged one sample before the computed count and toggled exactly at that count. A behavioural monitor runs in every cycle and checks the toggle-ordering rules and data stability at the ports. A queue model checks ordering and completeness at each consumption, while the producer and consumer use random stall lengths.

// File: rtl/mp_pkg.sv
package mp_pkg;
  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/mp_celem.sv
module mp_celem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic c_o,
  output logic c_nxt_o,
  output logic fire_o
);
  logic c_q, c_d;

  always_comb c_d = (a_i == b_i) ? a_i : c_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) c_q <= 1'b0;
    else         c_q <= c_d;

  assign c_o     = c_q;
  assign c_nxt_o = c_d;
  assign fire_o  = c_d ^ c_q;

  // R2: output moves only to a value both inputs agreed on
  a_r2_celem_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q != $past(c_q)) |-> (c_q == $past(a_i) && c_q == $past(b_i)));
endmodule

// File: rtl/mp_capture.sv
module mp_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_nxt_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;
  logic              edge_w;

  // either polarity of control transition loads
  assign edge_w = ctrl_nxt_i ^ ctrl_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     q_q <= '0;
    else if (edge_w) q_q <= d_i;

  assign q_o = q_q;

  a_r4_both_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i != $past(ctrl_i)) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/mp_req_delay.sv
module mp_req_delay #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic ctrl_i,
  input  logic ack_i,
  output logic req_o,
  output logic busy_o
);
  logic req_q;

  generate
    if (DELAY <= 1) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= ctrl_i;

      assign busy_o = req_q ^ ctrl_i;

      a_r7_req_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (req_q == ack_i));
    end else begin : g_count
      localparam int unsigned CW = mp_pkg::cnt_w(DELAY);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          cnt_q <= '0;
          req_q <= 1'b0;
        end else if (fire_i) begin
          cnt_q <= CW'(DELAY);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) req_q <= ~req_q;
        end

      assign busy_o = (cnt_q != '0);

      a_r7_req_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CW'(1)) |-> (req_q == ack_i));
      a_r5_req_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CW'(1)) |=> (req_q != $past(req_q)));
      a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(DELAY));
    end
  endgenerate

  assign req_o = req_q;
endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DELAY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_in_i,
  output logic              ack_out_o,
  input  logic [DATA_W-1:0] data_in_i,
  output logic              req_out_o,
  input  logic              ack_in_i,
  output logic [DATA_W-1:0] data_out_o
);
  logic ctrl, ctrl_nxt, fire, busy;

  mp_celem u_celem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_i     (req_in_i),
    .b_i     (~ack_in_i),
    .c_o     (ctrl),
    .c_nxt_o (ctrl_nxt),
    .fire_o  (fire)
  );

  mp_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_nxt_i (ctrl_nxt),
    .ctrl_i     (ctrl),
    .d_i        (data_in_i),
    .q_o        (data_out_o)
  );

  mp_req_delay #(.DELAY(DELAY)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .ctrl_i (ctrl),
    .ack_i  (ack_in_i),
    .req_o  (req_out_o),
    .busy_o (busy)
  );

  assign ack_out_o = ctrl;

  // R2: no new item while the previous outgoing request is still in flight
  a_r2_fire_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> !busy);
  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_out_o != ack_in_i) |=> $stable(data_out_o));
endmodule

// File: rtl/mp_chain.sv
module mp_chain #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAGES = 3,
  parameter int unsigned DELAY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ack_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o
);
  logic [STAGES:0]             req_l;
  logic [STAGES:0]             ack_l;
  logic [STAGES:0][DATA_W-1:0] data_l;

  assign req_l[0]      = req_i;
  assign data_l[0]     = data_i;
  assign ack_l[STAGES] = ack_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    mp_stage #(.DATA_W(DATA_W), .DELAY(DELAY)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_in_i   (req_l[i]),
      .ack_out_o  (ack_l[i]),
      .data_in_i  (data_l[i]),
      .req_out_o  (req_l[i+1]),
      .ack_in_i   (ack_l[i+1]),
      .data_out_o (data_l[i+1])
    );
  end

  assign ack_o  = ack_l[0];
  assign req_o  = req_l[STAGES];
  assign data_o = data_l[STAGES];

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!ack_o && !req_o && data_o == '0));
  a_r2_left_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != $past(ack_o)) |-> ($past(req_i) != $past(ack_o)));
endmodule

// File: tb/mp_chain_test.sv
module mp_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 3;
  localparam int D = 2;
  localparam int LAT = N * (D + 1);

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, ack_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ack_o, req_o;
  logic [W-1:0] data_o;

  int n_checks = 0, n_fail = 0, n_sent = 0, n_got = 0;
  logic [W-1:0] exp_q[$];
  bit cons_en = 1'b0, mon_on = 1'b0, done = 1'b0;
  int cons_max = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_chain #(.DATA_W(W), .STAGES(N), .DELAY(D)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .ack_o(ack_o), .data_i(data_i),
    .req_o(req_o), .ack_i(ack_i), .data_o(data_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic consume_one();
    if (exp_q.size() == 0) chk(1'b0, "R8 duplicate", int'(data_o), -1);
    else begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      chk(data_o == e, "R8", int'(data_o), int'(e));
    end
    n_got++;
    ack_i = ~ack_i;
  endtask

  task automatic send(input logic [W-1:0] v, input int pre);
    repeat (pre) @(negedge clk);
    data_i = v;
    req_i  = ~req_i;
    exp_q.push_back(v);
    n_sent++;
    do @(negedge clk); while (ack_o != req_i);
  endtask

  // consumer with random stalls
  initial forever begin
    @(negedge clk);
    if (cons_en && req_o != ack_i) begin
      repeat ($urandom_range(0, cons_max)) @(negedge clk);
      consume_one();
    end
  end

  // per-cycle protocol monitor at the ports
  logic p_req_i, p_ack_o, p_req_o, p_ack_i;
  logic [W-1:0] p_data_o;
  bit p_valid = 1'b0;
  initial forever begin
    @(negedge clk);
    #2;
    if (mon_on && p_valid) begin
      if (ack_o != p_ack_o) chk(p_req_i != p_ack_o, "R2", int'(p_req_i), int'(~p_ack_o));
      if (req_o != p_req_o) chk(p_req_o == p_ack_i, "R7", int'(p_req_o), int'(p_ack_i));
      if (p_req_o != p_ack_i) chk(data_o == p_data_o, "R6", int'(data_o), int'(p_data_o));
    end
    p_req_i = req_i; p_ack_o = ack_o; p_req_o = req_o; p_ack_i = ack_i; p_data_o = data_o;
    p_valid = mon_on;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic a_save;
    logic [W-1:0] first_item;
    int wait_cnt;
    repeat (3) @(negedge clk);
    #2;
    chk(ack_o == 1'b0 && req_o == 1'b0, "R1 in reset", int'({ack_o, req_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    #2;
    chk(ack_o == 1'b0, "R1", int'(ack_o), 0);
    chk(req_o == 1'b0, "R1", int'(req_o), 0);
    chk(data_o == '0, "R1", int'(data_o), 0);
    mon_on = 1'b1;

    // R3 / R5 latency through an empty chain
    @(negedge clk);
    data_i = 8'hA5; req_i = 1'b1; exp_q.push_back(8'hA5); n_sent++;
    @(negedge clk); #2;
    chk(ack_o == 1'b1, "R3", int'(ack_o), 1);
    repeat (LAT - 2) @(negedge clk);
    #2;
    chk(req_o == 1'b0, "R5 early", int'(req_o), 0);
    @(negedge clk); #2;
    chk(req_o == 1'b1, "R5", int'(req_o), 1);
    chk(data_o == 8'hA5, "R5", int'(data_o), 'hA5);
    @(negedge clk);
    consume_one();

    // R9 capacity with consumer stalled
    send(8'h11, 2);
    send(8'h22, 0);
    send(8'h33, 0);
    first_item = 8'h11;
    data_i = 8'h44; req_i = ~req_i; exp_q.push_back(8'h44); n_sent++;
    a_save = ack_o;
    repeat (40) @(negedge clk);
    #2;
    chk(ack_o == a_save, "R9 no ack when full", int'(ack_o), int'(a_save));
    chk(data_o == first_item, "R9 oldest shown", int'(data_o), int'(first_item));
    chk(req_o != ack_i, "R9 request outstanding", int'(req_o), int'(~ack_i));
    cons_en = 1'b1;
    do @(negedge clk); while (ack_o != req_i);

    // R10 / R4 alternating stream
    for (int k = 0; k < 20; k++)
      send((k % 2 == 0) ? 8'hFF : 8'h00, $urandom_range(0, 3));

    // R8 random values and delays
    cons_max = 6;
    for (int k = 0; k < 40; k++)
      send(W'($urandom), $urandom_range(0, 6));
    cons_max = 0;
    for (int k = 0; k < 10; k++)
      send(W'(k * 37 + 5), 0);

    wait_cnt = 0;
    while (exp_q.size() != 0 && wait_cnt < 2000) begin
      @(negedge clk);
      wait_cnt++;
    end
    repeat (LAT + 4) @(negedge clk);
    #2;
    chk(exp_q.size() == 0, "R10 stream drained", exp_q.size(), 0);
    chk(n_got == n_sent, "R8 count", n_got, n_sent);
    chk(req_o == ack_i, "R8 no extra item", int'(req_o), int'(ack_i));
    finish_run();
  end
endmodule